// File: doc/BRIEF.md
# Valley-Switching Gate Cycle Sequencer

This block produces the gate signal of a boost power switch, one switching cycle at a time. An upstream control-law block supplies an on-time request and a minimum off-time request, both in clock cycles. Three comparator outputs arrive asynchronously and pass through two-flop synchronizers. The first comparator marks when the auxiliary winding is below zero. The second is the normal current-limit threshold. The third is a severe overcurrent clamp.

Each cycle begins with a blanked on phase in which current sensing is ignored, followed by a sensed on phase. An off phase of at least the requested length comes next. The block then hunts for a qualified valley. A valley counts only when the synchronized zero-crossing signal falls after staying high for a minimum number of cycles. Shorter high periods are rejected as glitches. If no valley arrives within a maximum wait, a cycle is forced. A clamp event while the gate is on ends the pulse and starts a fixed hold-off, flagged on a status output. Dropping the enable input turns the gate off in the same cycle and returns the sequencer to idle.

States: IDLE (gate low, waiting for enable), BLANK (gate high, sensing ignored), SENSE (gate high, current limit active), OFF (gate low, minimum off-time), HUNT (gate low, waiting for a valley), HOLD (gate low, restart hold-off). The transitions are named as follows:
- start: IDLE to BLANK, one clock after enable is seen high.
- unblank: BLANK to SENSE.
- ton_done: BLANK or SENSE to OFF when the on-time count is reached.
- cs_trip: SENSE to OFF on the current-limit comparator.
- clamp_trip: BLANK or SENSE to HOLD.
- off_done: OFF to HUNT.
- valley_start: HUNT to BLANK on a qualified valley.
- forced_start: HUNT to BLANK when the maximum wait runs out.
- hold_done: HOLD to IDLE.
- disable: any state to IDLE while enable is low.

Top module: `valley_gate_sequencer`

## Requirements
- R1: While reset is asserted, `gate` and `restart_hold` are low. With `enable` low the sequencer stays idle and `gate` stays low.
- R2: When `enable` is seen high at a clock edge in IDLE, `gate` goes high after that edge, starting the first cycle without waiting for a valley.
- R3: Without current-limit or clamp events, each gate pulse lasts exactly `ton_req` clock cycles. A request of 0 is treated as 1.
- R4: The synchronized current-limit comparator is ignored during the first LEB_CYC cycles of each pulse. If it is high continuously, the pulse lasts min(`ton_req`, LEB_CYC+1) cycles.
- R5: After a pulse, `gate` stays low for at least `toff_req` cycles (0 treated as 1). If no qualified valley follows, the next pulse is forced, giving a low time of `toff_req` + MAXWAIT_CYC cycles.
- R6: A valley is qualified only when the zero-crossing input falls after being high for at least QUAL_CYC cycles. If the raw input is driven high from the W-th to the (W+H-1)-th low cycle after a pulse (counting from 0), a qualified valley starts the next pulse after a low time of W+H+3 cycles. A high period of H < QUAL_CYC is ignored.
- R7: A qualified valley that lands before the off-time has elapsed (W+H+3 ≤ `toff_req`) is ignored, and the cycle falls back to the forced start.
- R8: A clamp input raised in the j-th on cycle (counting from 0), including cycles inside the blanking window, ends the pulse after j+3 cycles. `restart_hold` is then high for exactly RESTART_CYC cycles, and the next pulse begins one cycle after it falls.
- R9: A clamp input raised while the gate is low has no effect on the low time, and `restart_hold` stays low.
- R10: `enable` going low forces `gate` low in the same cycle and returns the sequencer to IDLE at the next edge, which also cancels a running hold-off. On re-enable, a pulse starts one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run enable; low forces the gate off and resets to idle |
| ton_req | input | TW | Requested on-time in cycles |
| toff_req | input | TW | Requested minimum off-time in cycles |
| zcd_cmp | input | 1 | Asynchronous zero-crossing comparator (high while the winding is below zero) |
| cs_cmp | input | 1 | Asynchronous current-limit comparator |
| clamp_cmp | input | 1 | Asynchronous severe-overcurrent comparator |
| gate | output | 1 | Switch gate command |
| restart_hold | output | 1 | High during the restart hold-off |

## Verification
The bench sweeps the start offset and high length of the zero-crossing input over a grid. The grid covers the off-time boundary, the maximum-wait boundary and the qualification length on both sides. A design that counts the high time one cycle short would accept a three-cycle glitch. A design that looks for valleys during the off phase would start pulses early. The bench also runs a continuous current-limit input against on-times below, at and above the blanking length; a pulse cut shorter than the blanking window shows that blanking is missing. Clamp events are placed inside the blanking window and during the off phase. This catches a clamp that is wrongly blanked or acts while the gate is off. The hold-off length is counted exactly, and enable is dropped in the middle of a hold-off.

// File: rtl/vgs_pkg.sv
package vgs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_BLANK = 3'd1,
        ST_SENSE = 3'd2,
        ST_OFF   = 3'd3,
        ST_HUNT  = 3'd4,
        ST_HOLD  = 3'd5
    } vgs_state_e;

    function automatic int vgs_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/vgs_sync.sv
module vgs_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] synced
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q;
        logic stable_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q   <= 1'b0;
                stable_q <= 1'b0;
            end else begin
                meta_q   <= raw[i];
                stable_q <= meta_q;
            end
        end

        assign synced[i] = stable_q;
    end

endmodule

// File: rtl/vgs_valley_qual.sv
module vgs_valley_qual #(
    parameter int QUAL_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic zs,
    output logic valley
);

    localparam int HW = $clog2(QUAL_CYC + 1);
    localparam logic [HW-1:0] QUAL_TOP = HW'(QUAL_CYC);

    logic [HW-1:0] hi_cnt;

    // Counts consecutive high cycles, saturating at the qualification length.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt <= '0;
        end else if (zs) begin
            if (hi_cnt != QUAL_TOP) begin
                hi_cnt <= hi_cnt + HW'(1);
            end
        end else begin
            hi_cnt <= '0;
        end
    end

    assign valley = !zs && (hi_cnt == QUAL_TOP);

    // R6: a valley only appears on the cycle right after the input fell
    p_valley_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valley |-> ($past(zs) && !zs));

    // R6: the high-time counter never passes its saturation value
    p_hicnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hi_cnt <= QUAL_TOP);

endmodule

// File: rtl/valley_gate_sequencer.sv
module valley_gate_sequencer
    import vgs_pkg::*;
#(
    parameter int TW          = 16,
    parameter int QUAL_CYC    = 10,
    parameter int LEB_CYC     = 15,
    parameter int RESTART_CYC = 80000,
    parameter int MAXWAIT_CYC = 2000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic [TW-1:0] ton_req,
    input  logic [TW-1:0] toff_req,
    input  logic          zcd_cmp,
    input  logic          cs_cmp,
    input  logic          clamp_cmp,
    output logic          gate,
    output logic          restart_hold
);

    localparam int CNT_TOP = vgs_max(vgs_max(1 << TW, RESTART_CYC),
                                     vgs_max(MAXWAIT_CYC, LEB_CYC));
    localparam int CW      = $clog2(CNT_TOP + 1);
    localparam logic [CW-1:0] LEB_LAST     = CW'(LEB_CYC - 1);
    localparam logic [CW-1:0] RESTART_LAST = CW'(RESTART_CYC - 1);
    localparam logic [CW-1:0] WAIT_LAST    = CW'(MAXWAIT_CYC - 1);

    vgs_state_e    state, state_nx;
    logic [CW-1:0] cnt;
    logic [2:0]    cmp_s;
    logic          zs, cs_s, clamp_s;
    logic          valley;
    logic [TW-1:0] ton_last, toff_last;
    logic          gate_on;

    vgs_sync #(.W(3)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    ({clamp_cmp, cs_cmp, zcd_cmp}),
        .synced (cmp_s)
    );

    assign zs      = cmp_s[0];
    assign cs_s    = cmp_s[1];
    assign clamp_s = cmp_s[2];

    vgs_valley_qual #(.QUAL_CYC(QUAL_CYC)) u_qual (
        .clk    (clk),
        .rst_n  (rst_n),
        .zs     (zs),
        .valley (valley)
    );

    // Last cycle index of each timed phase; a zero request acts as one.
    assign ton_last  = (ton_req  == '0) ? '0 : ton_req  - TW'(1);
    assign toff_last = (toff_req == '0) ? '0 : toff_req - TW'(1);

    // Next-state logic
    always_comb begin
        state_nx = state;
        if (!enable) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  state_nx = ST_BLANK;
                ST_BLANK: begin
                    if (clamp_s)                       state_nx = ST_HOLD;
                    else if (cnt >= CW'(ton_last))     state_nx = ST_OFF;
                    else if (cnt == LEB_LAST)          state_nx = ST_SENSE;
                end
                ST_SENSE: begin
                    if (clamp_s)                       state_nx = ST_HOLD;
                    else if (cs_s)                     state_nx = ST_OFF;
                    else if (cnt >= CW'(ton_last))     state_nx = ST_OFF;
                end
                ST_OFF: begin
                    if (cnt >= CW'(toff_last))         state_nx = ST_HUNT;
                end
                ST_HUNT: begin
                    if (valley)                        state_nx = ST_BLANK;
                    else if (cnt == WAIT_LAST)         state_nx = ST_BLANK;
                end
                ST_HOLD: begin
                    if (cnt == RESTART_LAST)           state_nx = ST_IDLE;
                end
                default:                               state_nx = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Phase counter: restarts on every phase change except unblank,
    // so the on-time count runs across BLANK and SENSE.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if ((state_nx != state) &&
                     !(state == ST_BLANK && state_nx == ST_SENSE)) begin
            cnt <= '0;
        end else if (state != ST_IDLE) begin
            cnt <= cnt + CW'(1);
        end
    end

    // Outputs
    always_comb begin
        gate_on      = (state == ST_BLANK) || (state == ST_SENSE);
        gate         = gate_on && enable;
        restart_hold = (state == ST_HOLD);
    end

    // R10: a low enable sends the sequencer to idle at the next edge
    p_enable_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (state == ST_IDLE));

    // R8: a clamp seen while the gate is on leads into the hold-off
    p_clamp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && gate_on && clamp_s) |=> (state == ST_HOLD));

    // R8: the gate is never high during the hold-off
    p_hold_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        restart_hold |-> !gate);

    // R4: current-limit after blanking ends the pulse
    p_cs_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state == ST_SENSE && cs_s && !clamp_s) |=> (state == ST_OFF));

    // R4: sensing only starts once the blanking window has elapsed
    p_blank_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SENSE) |-> (cnt >= LEB_LAST + CW'(1)));

    // R5: valley hunting never outlasts the maximum wait
    p_hunt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HUNT) |-> (cnt <= WAIT_LAST));

endmodule

// File: tb/valley_gate_sequencer_bench.sv
module valley_gate_sequencer_bench;

    localparam int TW      = 8;
    localparam int QUAL    = 4;
    localparam int LEB     = 6;
    localparam int RESTART = 50;
    localparam int MAXW    = 30;
    localparam int TOFF    = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic [TW-1:0] ton_req = TW'(5);
    logic [TW-1:0] toff_req = TW'(TOFF);
    logic          zcd_cmp = 1'b0;
    logic          cs_cmp = 1'b0;
    logic          clamp_cmp = 1'b0;
    logic          gate;
    logic          restart_hold;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    valley_gate_sequencer #(
        .TW(TW), .QUAL_CYC(QUAL), .LEB_CYC(LEB),
        .RESTART_CYC(RESTART), .MAXWAIT_CYC(MAXW)
    ) u_valley_gate_sequencer (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .ton_req(ton_req), .toff_req(toff_req),
        .zcd_cmp(zcd_cmp), .cs_cmp(cs_cmp), .clamp_cmp(clamp_cmp),
        .gate(gate), .restart_hold(restart_hold)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog: run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Called at a negedge; measures the pulse in progress (or the next one)
    // and the low time after it. Returns at the negedge where gate is high again.
    task automatic meas(input int w, input int h, input int clamp_on_idx,
                        input bit clamp_off,
                        output int on_w, output int gap, output int holds);
        on_w = 0; gap = 0; holds = 0;
        while (gate == 1'b0) @(negedge clk);
        while (gate == 1'b1) begin
            if (on_w == clamp_on_idx)     clamp_cmp = 1'b1;
            if (on_w == clamp_on_idx + 2) clamp_cmp = 1'b0;
            on_w++;
            @(negedge clk);
        end
        clamp_cmp = 1'b0;
        while (gate == 1'b0) begin
            zcd_cmp = (gap >= w) && (gap < w + h);
            if (clamp_off) clamp_cmp = (gap >= 2) && (gap < 4);
            holds += int'(restart_hold);
            gap++;
            @(negedge clk);
        end
        zcd_cmp = 1'b0;
        clamp_cmp = 1'b0;
    endtask

    function automatic int exp_gap(input int w, input int h);
        int t;
        t = w + h + 3;
        if (h >= QUAL && t >= TOFF + 1 && t <= TOFF + MAXW) return t;
        return TOFF + MAXW;
    endfunction

    initial begin
        int on_w, gap, holds, e;

        // R1: reset state
        #5;
        check("R1 gate in reset", int'(gate), 0);
        check("R1 hold in reset", int'(restart_hold), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 idle with enable low", int'(gate), 0);

        // R2: first pulse one clock after enable
        enable = 1'b1;
        @(negedge clk);
        check("R2 first pulse start", int'(gate), 1);

        // R3 and R5 baseline
        meas(0, 0, -1, 1'b0, on_w, gap, holds);
        check("R3 on width ton=5", on_w, 5);
        check("R5 forced gap", gap, TOFF + MAXW);

        // R3: on-time sweep
        for (int t = 0; t <= 9; t++) begin
            ton_req = TW'(t);
            meas(0, 0, -1, 1'b0, on_w, gap, holds);
            meas(0, 0, -1, 1'b0, on_w, gap, holds);
            check($sformatf("R3 on width ton=%0d", t), on_w, (t == 0) ? 1 : t);
        end
        ton_req = TW'(5);

        // R5: off-time sweep with forced starts
        for (int k = 0; k < 4; k++) begin
            int tf;
            tf = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 5 : 12;
            toff_req = TW'(tf);
            meas(0, 0, -1, 1'b0, on_w, gap, holds);
            meas(0, 0, -1, 1'b0, on_w, gap, holds);
            check($sformatf("R5 forced gap toff=%0d", tf), gap,
                  ((tf == 0) ? 1 : tf) + MAXW);
        end
        toff_req = TW'(TOFF);

        // R6 / R7: valley sweep over offset and high length
        for (int wi = 0; wi < 6; wi++) begin
            int w;
            w = (wi == 0) ? 0 : (wi == 1) ? 1 : (wi == 2) ? 2 :
                (wi == 3) ? 5 : (wi == 4) ? 20 : 36;
            for (int h = 1; h <= 6; h++) begin
                meas(0, 0, -1, 1'b0, on_w, gap, holds);
                meas(w, h, -1, 1'b0, on_w, gap, holds);
                e = exp_gap(w, h);
                if (h >= QUAL && w + h + 3 <= TOFF)
                    check($sformatf("R7 early valley w=%0d h=%0d", w, h), gap, e);
                else
                    check($sformatf("R6 valley w=%0d h=%0d", w, h), gap, e);
            end
        end

        // R4: continuous current-limit against several on-times
        cs_cmp = 1'b1;
        for (int k = 0; k < 6; k++) begin
            int t;
            t = (k == 0) ? 1 : (k == 1) ? 3 : (k == 2) ? 6 :
                (k == 3) ? 7 : (k == 4) ? 8 : 12;
            ton_req = TW'(t);
            meas(0, 0, -1, 1'b0, on_w, gap, holds);
            meas(0, 0, -1, 1'b0, on_w, gap, holds);
            check($sformatf("R4 cs width ton=%0d", t), on_w, (t < LEB + 1) ? t : LEB + 1);
        end
        cs_cmp = 1'b0;

        // R8: clamp inside blanking and after it
        ton_req = TW'(20);
        meas(0, 0, -1, 1'b0, on_w, gap, holds);
        meas(0, 0, 1, 1'b0, on_w, gap, holds);
        check("R8 clamp in blank width", on_w, 4);
        check("R8 hold-off gap", gap, RESTART + 1);
        check("R8 hold flag cycles", holds, RESTART);
        meas(0, 0, 8, 1'b0, on_w, gap, holds);
        check("R8 clamp after blank width", on_w, 11);
        check("R8 hold-off gap 2", gap, RESTART + 1);
        check("R8 hold flag cycles 2", holds, RESTART);

        // R9: clamp while gate low is ignored
        ton_req = TW'(5);
        meas(0, 0, -1, 1'b0, on_w, gap, holds);
        meas(0, 0, -1, 1'b1, on_w, gap, holds);
        check("R9 clamp during off gap", gap, TOFF + MAXW);
        check("R9 clamp during off hold", holds, 0);

        // R10: enable drop mid-pulse
        @(negedge clk);
        enable = 1'b0;
        #1;
        check("R10 gate drops same cycle", int'(gate), 0);
        repeat (5) @(negedge clk);
        check("R10 stays off while disabled", int'(gate), 0);
        enable = 1'b1;
        @(negedge clk);
        check("R10 restart one clock later", int'(gate), 1);

        // R10: enable drop cancels a hold-off
        ton_req = TW'(20);
        meas(0, 0, -1, 1'b0, on_w, gap, holds);
        while (gate == 1'b1) begin
            clamp_cmp = 1'b1;
            @(negedge clk);
        end
        clamp_cmp = 1'b0;
        repeat (3) @(negedge clk);
        check("R10 in hold-off", int'(restart_hold), 1);
        enable = 1'b0;
        @(negedge clk);
        check("R10 hold cancelled", int'(restart_hold), 0);
        enable = 1'b1;
        @(negedge clk);
        check("R10 pulse after cancel", int'(gate), 1);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule